// File: doc/BRIEF.md
# Asynchronous SRAM Byte-Lane Controller

This block sits between a synchronous host and an external asynchronous static RAM of 128K words by 16 bits. The host hands over one access at a time: address, write data, a read/write flag and one enable bit per byte lane. The controller then drives the active-low memory controls, the address bus and a split data bus (value, sampled input, per-lane output enable). When the access is over it raises a one-cycle done pulse, with the read data for reads.

The memory has no clock, so every access is timed by counting clock cycles. Three cycle counts are derived at elaboration from a clock-period parameter and a speed-grade parameter (55 or 70 ns), each rounded up to whole cycles. These are the read cycle, the write pulse and the write cycle. Between accesses the chip is deselected, which lets the memory fall into its automatic power-down state.

Top module: `async_sram_ctl`

## Requirements
- R1: While chip enable is low, `memAddr` equals the address of the accepted request and does not change.
- R2: A read holds chip enable and output enable low and write enable high for RD_CYC cycles, where RD_CYC = ceil(read cycle time / clock period) (6 at 10 ns, 55 ns grade). It captures the data on the edge that ends the last of those cycles. `rspDone` and `rspRdData` are valid in the cycle after that edge.
- R3: In a read, a lane whose enable bit is 0 keeps its strobe high. It returns 8'h00 in `rspRdData`, whatever is on the bus. Lane 0 is bits 7..0 and lane 1 is bits 15..8.
- R4: Write enable is low only while chip enable is low and output enable is high. Both fall on the same edge, so there are zero cycles of address setup.
- R5: A `memDqOe` bit is high only while write enable is low and that lane's enable bit is 1.
- R6: A write holds write enable low for WP_CYC cycles, the rounded-up maximum of pulse width, chip-enable-to-end and data setup (4 at 10 ns). It holds chip enable low for WC_CYC cycles, the rounded-up write cycle time and at least WP_CYC (6 at 10 ns). Done follows in the next cycle.
- R7: In a write, a lane whose enable bit is 0 keeps its strobe high and its memory byte is left unchanged.
- R8: Chip enable is high whenever no access is in progress, including the cycle in which `rspDone` is high. With chip enable high, write enable, output enable and both strobes are high.
- R9: A request with both enable bits 0 gives `rspDone` in the next cycle. Chip enable is never asserted and no memory content changes.
- R10: During and after reset, all memory controls are high, `memDqOe` is 0, `rspDone` is 0 and `reqReady` is 1.
- R11: `reqReady` is low from the cycle after a request with any enable bit set is accepted until its done cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| reqValid | input | 1 | Request present |
| reqReady | output | 1 | Controller idle, request accepted on this edge |
| reqWrite | input | 1 | 1 = write, 0 = read |
| reqAddr | input | 17 | Word address |
| reqWrData | input | 16 | Write data |
| reqBe | input | 2 | Per-lane enable, bit 0 = bits 7..0 |
| rspDone | output | 1 | One-cycle completion pulse |
| rspRdData | output | 16 | Read data, valid with rspDone after a read |
| memCeN | output | 1 | Chip enable, active low |
| memWeN | output | 1 | Write enable, active low |
| memOeN | output | 1 | Output enable, active low |
| memLaneN | output | 2 | Byte strobes, active low, bit 0 = lower lane |
| memAddr | output | 17 | Memory address |
| memDqOut | output | 16 | Data driven toward memory |
| memDqIn | input | 16 | Data sampled from memory |
| memDqOe | output | 2 | Per-lane data drive enable |

## Verification
The bench places a request at a falling edge and counts falling edges from the accepting edge. Chip enable must be seen low at edges 1 to 6 and write enable at edges 1 to 4. `rspDone` is due at edge 7 for any access with an enabled lane, and at edge 1 for a request with no lanes enabled. The memory model presents valid data only from the sixth cycle of a read, so a capture one edge early returns the filler byte. Each task compares the edge counts and the returned data against these fixed numbers.

// File: rtl/sram_ctl_pkg.sv
package sram_ctl_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_READ  = 2'd1,
    ST_WRITE = 2'd2
  } ctlState_t;

  // Strobes from control to datapath: pulses for this edge plus registered pin levels
  typedef struct packed {
    logic load;
    logic capture;
    logic ceOn;
    logic oeOn;
    logic weOn;
  } sramStrobes_t;

  function automatic int ceilCycles(input int ns, input int periodNs);
    int c;
    c = (ns + periodNs - 1) / periodNs;
    return (c < 1) ? 1 : c;
  endfunction

endpackage

// File: rtl/sram_ctl_fsm.sv
module sram_ctl_fsm
  import sram_ctl_pkg::*;
#(
  parameter int LANES  = 2,
  parameter int RD_CYC = 6,
  parameter int WP_CYC = 4,
  parameter int WC_CYC = 6,
  parameter int CNT_W  = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             reqValid,
  input  logic             reqWrite,
  input  logic [LANES-1:0] reqBe,
  output logic             reqReady,
  output logic             rspDone,
  output sramStrobes_t     strobes
);

  localparam logic [CNT_W-1:0] RD_LAST = CNT_W'(RD_CYC - 1);
  localparam logic [CNT_W-1:0] WC_LAST = CNT_W'(WC_CYC - 1);
  localparam logic [CNT_W-1:0] WP_LIM  = CNT_W'(WP_CYC);

  ctlState_t        state, stateNxt;
  logic [CNT_W-1:0] cnt, cntNxt;
  logic             doneNxt;
  logic             loadNow, capNow;
  logic             ceQ, oeQ, weQ;
  logic             ceNxt, oeNxt, weNxt;

  always_comb begin
    stateNxt = state;
    cntNxt   = cnt;
    doneNxt  = 1'b0;
    loadNow  = 1'b0;
    capNow   = 1'b0;
    unique case (state)
      ST_IDLE: begin
        if (reqValid) begin
          if (reqBe == '0) begin
            doneNxt = 1'b1;
          end else begin
            loadNow  = 1'b1;
            cntNxt   = '0;
            stateNxt = reqWrite ? ST_WRITE : ST_READ;
          end
        end
      end
      ST_READ: begin
        if (cnt == RD_LAST) begin
          capNow   = 1'b1;
          doneNxt  = 1'b1;
          cntNxt   = '0;
          stateNxt = ST_IDLE;
        end else begin
          cntNxt = cnt + 1'b1;
        end
      end
      ST_WRITE: begin
        if (cnt == WC_LAST) begin
          doneNxt  = 1'b1;
          cntNxt   = '0;
          stateNxt = ST_IDLE;
        end else begin
          cntNxt = cnt + 1'b1;
        end
      end
      default: begin
        cntNxt   = '0;
        stateNxt = ST_IDLE;
      end
    endcase
  end

  // Pin levels follow the next state, registered so the pins do not glitch
  always_comb begin
    ceNxt = (stateNxt != ST_IDLE);
    oeNxt = (stateNxt == ST_READ);
    weNxt = (stateNxt == ST_WRITE) && (cntNxt < WP_LIM);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= ST_IDLE;
      cnt     <= '0;
      rspDone <= 1'b0;
      ceQ     <= 1'b0;
      oeQ     <= 1'b0;
      weQ     <= 1'b0;
    end else begin
      state   <= stateNxt;
      cnt     <= cntNxt;
      rspDone <= doneNxt;
      ceQ     <= ceNxt;
      oeQ     <= oeNxt;
      weQ     <= weNxt;
    end
  end

  assign reqReady        = (state == ST_IDLE);
  assign strobes.load    = loadNow;
  assign strobes.capture = capNow;
  assign strobes.ceOn    = ceQ;
  assign strobes.oeOn    = oeQ;
  assign strobes.weOn    = weQ;

endmodule

// File: rtl/sram_ctl_datapath.sv
module sram_ctl_datapath
  import sram_ctl_pkg::*;
#(
  parameter int ADDR_W = 17,
  parameter int LANES  = 2,
  parameter int DATA_W = LANES * 8
) (
  input  logic              clk,
  input  logic              rst,
  input  sramStrobes_t      strobes,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [DATA_W-1:0] reqWrData,
  input  logic [LANES-1:0]  reqBe,
  output logic [DATA_W-1:0] rspRdData,
  output logic              memCeN,
  output logic              memWeN,
  output logic              memOeN,
  output logic [LANES-1:0]  memLaneN,
  output logic [ADDR_W-1:0] memAddr,
  output logic [DATA_W-1:0] memDqOut,
  input  logic [DATA_W-1:0] memDqIn,
  output logic [LANES-1:0]  memDqOe
);

  logic [ADDR_W-1:0] addrQ;
  logic [DATA_W-1:0] wrDataQ;
  logic [LANES-1:0]  beQ;
  logic [DATA_W-1:0] rdDataQ;
  logic [DATA_W-1:0] rdMasked;

  always_ff @(posedge clk) begin
    if (rst) begin
      addrQ   <= '0;
      wrDataQ <= '0;
      beQ     <= '0;
    end else if (strobes.load) begin
      addrQ   <= reqAddr;
      wrDataQ <= reqWrData;
      beQ     <= reqBe;
    end
  end

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign rdMasked[g*8 +: 8] = beQ[g] ? memDqIn[g*8 +: 8] : 8'h00;
    assign memLaneN[g]        = ~(strobes.ceOn & beQ[g]);
    assign memDqOe[g]         = strobes.weOn & beQ[g];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdDataQ <= '0;
    end else if (strobes.capture) begin
      rdDataQ <= rdMasked;
    end
  end

  assign memCeN    = ~strobes.ceOn;
  assign memOeN    = ~strobes.oeOn;
  assign memWeN    = ~strobes.weOn;
  assign memAddr   = addrQ;
  assign memDqOut  = wrDataQ;
  assign rspRdData = rdDataQ;

endmodule

// File: rtl/async_sram_ctl.sv
module async_sram_ctl
  import sram_ctl_pkg::*;
#(
  parameter int CLK_PERIOD_NS  = 10,
  parameter int SPEED_GRADE_NS = 55,
  parameter int ADDR_W         = 17,
  parameter int DATA_W         = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reqValid,
  output logic              reqReady,
  input  logic              reqWrite,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [DATA_W-1:0] reqWrData,
  input  logic [DATA_W/8-1:0] reqBe,
  output logic              rspDone,
  output logic [DATA_W-1:0] rspRdData,
  output logic              memCeN,
  output logic              memWeN,
  output logic              memOeN,
  output logic [DATA_W/8-1:0] memLaneN,
  output logic [ADDR_W-1:0] memAddr,
  output logic [DATA_W-1:0] memDqOut,
  input  logic [DATA_W-1:0] memDqIn,
  output logic [DATA_W/8-1:0] memDqOe
);

  localparam int LANES   = DATA_W / 8;
  localparam bit FAST    = (SPEED_GRADE_NS <= 55);
  localparam int T_RC_NS = FAST ? 55 : 70;
  localparam int T_WC_NS = FAST ? 55 : 70;
  localparam int T_WP_NS = FAST ? 40 : 50;
  localparam int T_CW_NS = FAST ? 40 : 50;
  localparam int T_DS_NS = FAST ? 35 : 40;
  localparam int T_PULSE = (T_WP_NS > T_CW_NS) ?
                           ((T_WP_NS > T_DS_NS) ? T_WP_NS : T_DS_NS) :
                           ((T_CW_NS > T_DS_NS) ? T_CW_NS : T_DS_NS);
  localparam int RD_CYC  = ceilCycles(T_RC_NS, CLK_PERIOD_NS);
  localparam int WP_CYC  = ceilCycles(T_PULSE, CLK_PERIOD_NS);
  localparam int WC_RAW  = ceilCycles(T_WC_NS, CLK_PERIOD_NS);
  localparam int WC_CYC  = (WC_RAW > WP_CYC) ? WC_RAW : WP_CYC;
  localparam int CNT_MAX = (RD_CYC > WC_CYC) ? RD_CYC : WC_CYC;
  localparam int CNT_W   = $clog2(CNT_MAX + 1);

  sramStrobes_t strobes;

  sram_ctl_fsm #(
    .LANES (LANES),
    .RD_CYC(RD_CYC),
    .WP_CYC(WP_CYC),
    .WC_CYC(WC_CYC),
    .CNT_W (CNT_W)
  ) u_fsm (
    .clk     (clk),
    .rst     (rst),
    .reqValid(reqValid),
    .reqWrite(reqWrite),
    .reqBe   (reqBe),
    .reqReady(reqReady),
    .rspDone (rspDone),
    .strobes (strobes)
  );

  sram_ctl_datapath #(
    .ADDR_W(ADDR_W),
    .LANES (LANES),
    .DATA_W(DATA_W)
  ) u_dp (
    .clk      (clk),
    .rst      (rst),
    .strobes  (strobes),
    .reqAddr  (reqAddr),
    .reqWrData(reqWrData),
    .reqBe    (reqBe),
    .rspRdData(rspRdData),
    .memCeN   (memCeN),
    .memWeN   (memWeN),
    .memOeN   (memOeN),
    .memLaneN (memLaneN),
    .memAddr  (memAddr),
    .memDqOut (memDqOut),
    .memDqIn  (memDqIn),
    .memDqOe  (memDqOe)
  );

endmodule

// File: rtl/sram_ctl_checker.sv
module sram_ctl_checker #(
  parameter int ADDR_W = 17,
  parameter int LANES  = 2,
  parameter int RD_CYC = 6,
  parameter int WP_CYC = 4
) (
  input logic              clk,
  input logic              rst,
  input logic              memCeN,
  input logic              memWeN,
  input logic              memOeN,
  input logic [LANES-1:0]  memLaneN,
  input logic [ADDR_W-1:0] memAddr,
  input logic [LANES-1:0]  memDqOe,
  input logic              rspDone
);

  logic [7:0] ceLowCnt, weLowCnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      ceLowCnt <= '0;
      weLowCnt <= '0;
    end else begin
      ceLowCnt <= memCeN ? 8'd0 : ((ceLowCnt == 8'hFF) ? ceLowCnt : ceLowCnt + 8'd1);
      weLowCnt <= memWeN ? 8'd0 : ((weLowCnt == 8'hFF) ? weLowCnt : weLowCnt + 8'd1);
    end
  end

  // R1
  addr_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!memCeN && $past(!memCeN)) |-> $stable(memAddr));

  // R4
  we_frame_chk: assert property (@(posedge clk) disable iff (rst)
    !memWeN |-> (!memCeN && memOeN));

  // R4
  we_start_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(memWeN) |-> $fell(memCeN));

  // R5
  drive_window_chk: assert property (@(posedge clk) disable iff (rst)
    (memDqOe != '0) |-> !memWeN);

  // R6
  we_width_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(memWeN) |-> (weLowCnt == 8'(WP_CYC)));

  // R2
  rd_cycle_chk: assert property (@(posedge clk) disable iff (rst)
    ($rose(memCeN) && !$past(memOeN)) |-> (ceLowCnt == 8'(RD_CYC)));

  // R8
  idle_pins_chk: assert property (@(posedge clk) disable iff (rst)
    memCeN |-> (memWeN && memOeN && (memLaneN == '1)));

  // R8
  done_deselect_chk: assert property (@(posedge clk) disable iff (rst)
    rspDone |-> memCeN);

endmodule

bind async_sram_ctl sram_ctl_checker #(
  .ADDR_W(ADDR_W),
  .LANES (LANES),
  .RD_CYC(RD_CYC),
  .WP_CYC(WP_CYC)
) u_sramChk (
  .clk     (clk),
  .rst     (rst),
  .memCeN  (memCeN),
  .memWeN  (memWeN),
  .memOeN  (memOeN),
  .memLaneN(memLaneN),
  .memAddr (memAddr),
  .memDqOe (memDqOe),
  .rspDone (rspDone)
);

// File: tb/test_async_sram_ctl.sv
module test_async_sram_ctl;

  localparam int CLK_NS = 10;
  // 55 ns grade at 10 ns: read 55 -> 6, pulse 40 -> 4, write cycle 55 -> 6
  localparam int EXP_RD   = 6;
  localparam int EXP_WP   = 4;
  localparam int EXP_WC   = 6;
  localparam int EXP_LAT  = 7;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        reqValid = 1'b0;
  logic        reqReady;
  logic        reqWrite = 1'b0;
  logic [16:0] reqAddr = '0;
  logic [15:0] reqWrData = '0;
  logic [1:0]  reqBe = '0;
  logic        rspDone;
  logic [15:0] rspRdData;
  logic        memCeN, memWeN, memOeN;
  logic [1:0]  memLaneN;
  logic [16:0] memAddr;
  logic [15:0] memDqOut;
  logic [15:0] memDqIn;
  logic [1:0]  memDqOe;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;
  logic [16:0] curAddr = '0;

  logic [15:0] model [64];
  int readCnt = 0;

  async_sram_ctl #(
    .CLK_PERIOD_NS (CLK_NS),
    .SPEED_GRADE_NS(55)
  ) i_async_sram_ctl (
    .clk(clk), .rst(rst),
    .reqValid(reqValid), .reqReady(reqReady), .reqWrite(reqWrite),
    .reqAddr(reqAddr), .reqWrData(reqWrData), .reqBe(reqBe),
    .rspDone(rspDone), .rspRdData(rspRdData),
    .memCeN(memCeN), .memWeN(memWeN), .memOeN(memOeN), .memLaneN(memLaneN),
    .memAddr(memAddr), .memDqOut(memDqOut), .memDqIn(memDqIn), .memDqOe(memDqOe)
  );

  always #(CLK_NS/2) clk = ~clk;

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", req, act, exp);
    end
  endtask

  // Memory model: valid data only from the last read cycle, filler otherwise
  always @(posedge clk) begin
    if (!memCeN && !memOeN && memWeN) readCnt <= readCnt + 1;
    else readCnt <= 0;
  end

  always_comb begin
    memDqIn = 16'h5A5A;
    if (!memCeN && !memOeN && memWeN && readCnt >= EXP_RD - 1) begin
      for (int l = 0; l < 2; l++)
        if (!memLaneN[l]) memDqIn[l*8 +: 8] = model[memAddr[5:0]][l*8 +: 8];
    end
  end

  always @(negedge clk) begin
    if (!rst) begin
      if (!memCeN && !memWeN) begin
        for (int l = 0; l < 2; l++)
          if (!memLaneN[l] && memDqOe[l]) model[memAddr[5:0]][l*8 +: 8] <= memDqOut[l*8 +: 8];
      end
      if (!memCeN) check(memAddr == curAddr, "R1 address during access", 32'(memAddr), 32'(curAddr));
      if (!memWeN) check(memOeN == 1'b1, "R4 output enable high during write", 32'(memOeN), 32'd1);
      if (memWeN)  check(memDqOe == 2'b00, "R5 no drive while write enable high", 32'(memDqOe), 32'd0);
      if (memCeN)  check({memWeN, memOeN, memLaneN} == 4'hF, "R8 controls high when deselected",
                         32'({memWeN, memOeN, memLaneN}), 32'hF);
    end
  end

  task automatic access(input logic wr, input logic [16:0] a, input logic [15:0] d, input logic [1:0] be,
                        output logic [15:0] rd, output int lat, output int ceLow, output int weLow,
                        output logic ceAtDone);
    bit readyBad;
    lat = 0; ceLow = 0; weLow = 0; readyBad = 1'b0;
    check(reqReady == 1'b1, "R11 ready before request", 32'(reqReady), 32'd1);
    reqValid = 1'b1; reqWrite = wr; reqAddr = a; reqWrData = d; reqBe = be; curAddr = a;
    @(posedge clk); #1;
    reqValid = 1'b0;
    do begin
      @(negedge clk);
      lat++;
      if (!memCeN) ceLow++;
      if (!memWeN) weLow++;
      if (!rspDone && reqReady) readyBad = 1'b1;
    end while (!rspDone && lat < 50);
    rd = rspRdData;
    ceAtDone = memCeN;
    if (be != 2'b00) check(!readyBad, "R11 ready low during access", 32'(readyBad), 32'd0);
  endtask

  task automatic t_reset();
    check(memCeN && memWeN && memOeN && memLaneN == 2'b11, "R10 controls high in reset",
          32'({memCeN, memWeN, memOeN, memLaneN}), 32'h1F);
    check(memDqOe == 2'b00 && !rspDone, "R10 no drive, no done", 32'({memDqOe, rspDone}), 32'd0);
    check(reqReady == 1'b1, "R10 ready after reset", 32'(reqReady), 32'd1);
  endtask

  task automatic t_fullWriteRead();
    logic [15:0] rd; int lat, ceLow, weLow; logic ced;
    access(1'b1, 17'h1_0003, 16'hA5C3, 2'b11, rd, lat, ceLow, weLow, ced);
    check(lat == EXP_LAT, "R6 write done latency", 32'(lat), 32'(EXP_LAT));
    check(ceLow == EXP_WC, "R6 write chip enable cycles", 32'(ceLow), 32'(EXP_WC));
    check(weLow == EXP_WP, "R6 write pulse cycles", 32'(weLow), 32'(EXP_WP));
    check(ced == 1'b1, "R8 deselected at done", 32'(ced), 32'd1);
    check(model[3] == 16'hA5C3, "R6 word stored", 32'(model[3]), 32'hA5C3);
    access(1'b0, 17'h1_0003, 16'h0000, 2'b11, rd, lat, ceLow, weLow, ced);
    check(rd == 16'hA5C3, "R2 read data", 32'(rd), 32'hA5C3);
    check(lat == EXP_LAT, "R2 read done latency", 32'(lat), 32'(EXP_LAT));
    check(ceLow == EXP_RD, "R2 read chip enable cycles", 32'(ceLow), 32'(EXP_RD));
    check(weLow == 0, "R2 write enable high in read", 32'(weLow), 32'd0);
  endtask

  task automatic t_partialWrite();
    logic [15:0] rd; int lat, ceLow, weLow; logic ced;
    access(1'b1, 17'h0_0011, 16'h1122, 2'b11, rd, lat, ceLow, weLow, ced);
    access(1'b1, 17'h0_0011, 16'hFF33, 2'b01, rd, lat, ceLow, weLow, ced);
    access(1'b0, 17'h0_0011, 16'h0000, 2'b11, rd, lat, ceLow, weLow, ced);
    check(rd == 16'h1133, "R7 lower-lane write keeps upper byte", 32'(rd), 32'h1133);
    access(1'b1, 17'h0_0011, 16'h77EE, 2'b10, rd, lat, ceLow, weLow, ced);
    access(1'b0, 17'h0_0011, 16'h0000, 2'b11, rd, lat, ceLow, weLow, ced);
    check(rd == 16'h7733, "R7 upper-lane write keeps lower byte", 32'(rd), 32'h7733);
  endtask

  task automatic t_laneRead();
    logic [15:0] rd; int lat, ceLow, weLow; logic ced;
    access(1'b0, 17'h0_0011, 16'h0000, 2'b10, rd, lat, ceLow, weLow, ced);
    check(rd == 16'h7700, "R3 upper-lane read zeroes lower", 32'(rd), 32'h7700);
    access(1'b0, 17'h0_0011, 16'h0000, 2'b01, rd, lat, ceLow, weLow, ced);
    check(rd == 16'h0033, "R3 lower-lane read zeroes upper", 32'(rd), 32'h0033);
  endtask

  task automatic t_zeroBe();
    logic [15:0] rd; int lat, ceLow, weLow; logic ced;
    access(1'b1, 17'h0_0011, 16'hDEAD, 2'b00, rd, lat, ceLow, weLow, ced);
    check(lat == 1, "R9 empty request done next cycle", 32'(lat), 32'd1);
    check(ceLow == 0, "R9 chip enable stays high", 32'(ceLow), 32'd0);
    access(1'b0, 17'h0_0011, 16'h0000, 2'b11, rd, lat, ceLow, weLow, ced);
    check(rd == 16'h7733, "R9 memory unchanged", 32'(rd), 32'h7733);
  endtask

  task automatic t_backToBack();
    logic [15:0] rd; int lat, ceLow, weLow; logic ced;
    access(1'b1, 17'h0_0020, 16'hBEEF, 2'b11, rd, lat, ceLow, weLow, ced);
    check(ced == 1'b1, "R8 gap after first write", 32'(ced), 32'd1);
    access(1'b1, 17'h1_FF21, 16'hC0DE, 2'b11, rd, lat, ceLow, weLow, ced);
    check(ced == 1'b1, "R8 gap after second write", 32'(ced), 32'd1);
    access(1'b0, 17'h0_0020, 16'h0000, 2'b11, rd, lat, ceLow, weLow, ced);
    check(rd == 16'hBEEF, "R2 back-to-back read first word", 32'(rd), 32'hBEEF);
    access(1'b0, 17'h1_FF21, 16'h0000, 2'b11, rd, lat, ceLow, weLow, ced);
    check(rd == 16'hC0DE, "R2 back-to-back read second word", 32'(rd), 32'hC0DE);
  endtask

  task automatic t_idle();
    int lowSeen = 0;
    for (int i = 0; i < 10; i++) begin
      @(negedge clk);
      if (!memCeN) lowSeen++;
    end
    check(lowSeen == 0, "R8 chip enable high while idle", 32'(lowSeen), 32'd0);
  endtask

  initial begin
    for (int i = 0; i < 64; i++) model[i] = 16'h0000;
    repeat (3) @(posedge clk);
    @(negedge clk);
    t_reset();
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_fullWriteRead();
    t_partialWrite();
    t_laneRead();
    t_zeroBe();
    t_backToBack();
    t_idle();
    finished = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired actual %0d expected %0d", 20000, 0);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule